// File: doc/BRIEF.md
# Serial Command Port with Byte Resynchronisation

This block is the host-facing port of a converter device. A host acts as master on a four-wire serial link: chip select (`cs_n`), serial clock (`sclk`), data in (`sdi`) and data out (`sdo`). The port samples all three host inputs in the system clock domain through two-flop synchronizers and finds the SCLK edges there. Each byte shifted in, MSB first on SCLK rising edges, is a command. The port acts on it in one of three ways. It can write 24 bits to one of 32 internal registers. It can read one of those registers back on `sdo`. Or it can send a one-clock strobe to the rest of the device: start conversion, calibrate, power up, or power down and software reset.

The host may end a read after one, two or three bytes. Bytes the host shifts in during a read are decoded as commands as they arrive. A no-op byte lets the read go on. Any other command acts at once: a new read reloads the transmit buffer, and anything else ends the read. Byte alignment returns to zero on every CS falling edge. It can also be recovered without toggling CS by sending three or more all-ones bytes followed by 0xFE.

Top module: `cmd_serial_port`

## Requirements
- R1: After reset, `sdo` is high impedance, `cmd_ok` is 1, all strobes are low and every register reads 0.
- R2: While `cs_n` is high, `sdo` is high impedance and SCLK edges have no effect: they cause no strobe and no register change.
- R3: The byte `0 1 a4..a0 0` (bit 7 first) is a register write. The next 24 bits, MSB first, are written to register `a` on the 24th SCLK rising edge.
- R4: The byte `0 0 a4..a0 0` is a register read. Register `a` is driven on `sdo` MSB first. Each bit changes after an SCLK falling edge and is valid at the next rising edge. The host may stop after 8, 16 or 24 bits.
- R5: During a read, each byte on `sdi` is decoded. 0xFF and 0xFE continue the read. A read command restarts transmission with the new register. Any other command ends the read, after which `sdo` drives 0.
- R6: Byte `1110c000` gives a one-cycle `conv_go` with `conv_cont`=c, where 1 means continuous.
- R7: Byte `110 a2 a1 0 g o` gives a one-cycle `cal_go` with `cal_sel`={a2,a1}, `cal_gain`=g and `cal_offset`=o.
- R8: Byte 0xA0 gives a one-cycle `pwr_up_go`. Byte `100 s1 s0 000` with {s1,s0} equal to 00 (reset), 01 (standby) or 10 (sleep) gives `pwr_dn_go` with `pwr_dn_mode`={s1,s0}.
- R9: Every other byte, including 0x98, is invalid. It gives no strobe and drives `cmd_ok` to 0, where it stays until reset.
- R10: A CS falling edge resets bit alignment, so a partial byte shifted in before it is discarded.
- R11: A run of at least 31 consecutive 1 bits followed by a 0 (three 0xFF bytes then 0xFE) re-aligns the port to a byte boundary at that 0, even from a misaligned bit position.
- R12: At most one strobe is high in any cycle, and each lasts exactly one cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cs_n | input | 1 | Chip select, active low |
| sclk | input | 1 | Serial clock from host |
| sdi | input | 1 | Serial data from host |
| sdo | output | 1 | Serial data to host, high impedance while deselected |
| cmd_ok | output | 1 | 1 until an invalid command arrives |
| conv_go | output | 1 | Start-conversion strobe |
| conv_cont | output | 1 | Continuous-mode field of the last start command |
| cal_go | output | 1 | Calibration strobe |
| cal_sel | output | 2 | Channel-select field of the last calibrate command |
| cal_gain | output | 1 | Gain field of the last calibrate command |
| cal_offset | output | 1 | Offset field of the last calibrate command |
| pwr_up_go | output | 1 | Power-up strobe |
| pwr_dn_go | output | 1 | Power-down strobe |
| pwr_dn_mode | output | 2 | Mode field of the last power-down command |

## Verification
The assertions assume that every SCLK high and low phase lasts longer than the synchronizer depth plus two system clocks. They also assume that CS changes only while SCLK is low and that SDI is stable around each rising edge. If these hold, no two host edges merge or reorder in the sampled domain. The bench keeps to this by holding each SCLK phase for eight system clocks, changing SDI only at the start of a low phase, and moving CS only with SCLK low and idle. Random register traffic, random truncation lengths and random single command bytes run within the same timing, alongside directed misalignment and chaining sequences.

// File: rtl/cps_pkg.sv
package cps_pkg;
  localparam int CMD_W  = 8;
  localparam int ADDR_W = 5;

  typedef enum logic [2:0] {
    K_NOP, K_REG, K_CONV, K_CAL, K_PUP, K_PDN, K_BAD
  } cmd_kind_e;

  function automatic cmd_kind_e classify(input logic [CMD_W-1:0] b);
    if (b == 8'hFF || b == 8'hFE) return K_NOP;
    if (!b[7]) return b[0] ? K_BAD : K_REG;
    if (b[7:4] == 4'b1110) return (b[2:0] == 3'b000) ? K_CONV : K_BAD;
    if (b[7:5] == 3'b110) return b[2] ? K_BAD : K_CAL;
    if (b == 8'hA0) return K_PUP;
    if (b[7:5] == 3'b100 && b[2:0] == 3'b000 && b[4:3] != 2'b11) return K_PDN;
    return K_BAD;
  endfunction
endpackage

// File: rtl/cps_sync.sv
module cps_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic cs_n,
  input  logic sclk,
  input  logic sdi,
  output logic cs_q,
  output logic sdi_q,
  output logic sclk_rise,
  output logic sclk_fall,
  output logic cs_fall
);
  // bit order: {cs, sclk, sdi}
  localparam logic [2:0] IDLE = 3'b100;

  logic [2:0] stg [STAGES+1];
  logic [2:0] cur, prv;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i <= STAGES; i++) stg[i] <= IDLE;
    end else begin
      stg[0] <= {cs_n, sclk, sdi};
      for (int i = 1; i <= STAGES; i++) stg[i] <= stg[i-1];
    end
  end

  assign cur       = stg[STAGES-1];
  assign prv       = stg[STAGES];
  assign cs_q      = cur[2];
  assign sdi_q     = cur[0];
  assign sclk_rise = ~cur[2] & cur[1] & ~prv[1];
  assign sclk_fall = ~cur[2] & ~cur[1] & prv[1];
  assign cs_fall   = ~cur[2] & prv[2];
endmodule

// File: rtl/cps_regfile.sv
module cps_regfile #(
  parameter int AW = 5,
  parameter int DW = 24
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] rdata
);
  localparam int DEPTH = 1 << AW;

  logic [DW-1:0] mem [DEPTH];

  for (genvar g = 0; g < DEPTH; g++) begin : g_word
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                           mem[g] <= '0;
      else if (we && waddr == AW'(g))       mem[g] <= wdata;
    end
  end

  assign rdata = mem[raddr];
endmodule

// File: rtl/cps_tx.sv
module cps_tx #(
  parameter int DW = 24
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [DW-1:0] ld_data,
  input  logic          stop,
  input  logic          sclk_rise,
  input  logic          sclk_fall,
  output logic          busy,
  output logic          sdo_bit
);
  localparam int CW = $clog2(DW);

  logic [DW-1:0] sh;
  logic [CW-1:0] cnt;
  logic          fresh;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh <= '0; cnt <= '0; fresh <= 1'b0; busy <= 1'b0;
    end else if (load) begin
      sh <= ld_data; cnt <= '0; fresh <= 1'b1; busy <= 1'b1;
    end else if (stop) begin
      busy <= 1'b0;
    end else if (busy && sclk_rise) begin
      if (cnt == CW'(DW-1)) busy <= 1'b0;
      else                  cnt  <= cnt + 1'b1;
    end else if (busy && sclk_fall) begin
      // the falling edge right after the command byte keeps the MSB
      if (fresh) fresh <= 1'b0;
      else       sh    <= {sh[DW-2:0], 1'b0};
    end
  end

  assign sdo_bit = busy & sh[DW-1];

  assert_load_msb_R4: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> (busy && sdo_bit == $past(ld_data[DW-1])));
endmodule

// File: rtl/cmd_serial_port.sv
module cmd_serial_port #(
  parameter int DATA_W      = 24,
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       cs_n,
  input  logic       sclk,
  input  logic       sdi,
  output logic       sdo,
  output logic       cmd_ok,
  output logic       conv_go,
  output logic       conv_cont,
  output logic       cal_go,
  output logic [1:0] cal_sel,
  output logic       cal_gain,
  output logic       cal_offset,
  output logic       pwr_up_go,
  output logic       pwr_dn_go,
  output logic [1:0] pwr_dn_mode
);
  import cps_pkg::*;

  localparam int CNT_W    = $clog2(DATA_W);
  localparam int ONES_W   = $clog2(4*CMD_W);
  localparam int ONES_MAX = 4*CMD_W - 1;

  typedef enum logic {S_CMD, S_DATA} st_e;

  logic              cs_q, sdi_q, sclk_rise, sclk_fall, cs_fall;
  st_e               st;
  logic [CNT_W-1:0]  bit_cnt;
  logic [CMD_W-2:0]  cmd_sh;
  logic [DATA_W-2:0] wsh;
  logic [ADDR_W-1:0] waddr;
  logic [ONES_W-1:0] ones;
  logic [CMD_W-1:0]  in_byte;
  cmd_kind_e         kind;
  logic              rise_ok, resync, byte_done, rd_load, rd_stop, we;
  logic [DATA_W-1:0] rdata;
  logic              tx_busy, tx_bit;

  cps_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sclk(sclk), .sdi(sdi),
    .cs_q(cs_q), .sdi_q(sdi_q), .sclk_rise(sclk_rise),
    .sclk_fall(sclk_fall), .cs_fall(cs_fall)
  );

  assign rise_ok   = sclk_rise & ~cs_q;
  assign resync    = rise_ok & ~sdi_q & (ones == ONES_W'(ONES_MAX));
  assign in_byte   = {cmd_sh, sdi_q};
  assign kind      = classify(in_byte);
  assign byte_done = rise_ok & ~resync & (st == S_CMD) & (bit_cnt == CNT_W'(CMD_W-1));
  assign rd_load   = byte_done & (kind == K_REG) & ~in_byte[6];
  assign rd_stop   = cs_fall | cs_q | resync | (byte_done & (kind != K_NOP) & ~rd_load);
  assign we        = rise_ok & ~resync & (st == S_DATA) & (bit_cnt == CNT_W'(DATA_W-1));

  cps_regfile #(.AW(ADDR_W), .DW(DATA_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .we(we), .waddr(waddr),
    .wdata({wsh, sdi_q}), .raddr(in_byte[5:1]), .rdata(rdata)
  );

  cps_tx #(.DW(DATA_W)) u_tx (
    .clk(clk), .rst_n(rst_n), .load(rd_load), .ld_data(rdata), .stop(rd_stop),
    .sclk_rise(rise_ok), .sclk_fall(sclk_fall), .busy(tx_busy), .sdo_bit(tx_bit)
  );

  assign sdo = cs_q ? 1'bz : tx_bit;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= S_CMD; bit_cnt <= '0; cmd_sh <= '0; wsh <= '0; waddr <= '0;
      ones <= '0; cmd_ok <= 1'b1;
      conv_go <= 1'b0; cal_go <= 1'b0; pwr_up_go <= 1'b0; pwr_dn_go <= 1'b0;
      conv_cont <= 1'b0; cal_sel <= '0; cal_gain <= 1'b0; cal_offset <= 1'b0;
      pwr_dn_mode <= '0;
    end else begin
      conv_go <= 1'b0; cal_go <= 1'b0; pwr_up_go <= 1'b0; pwr_dn_go <= 1'b0;
      if (cs_fall) begin
        st <= S_CMD; bit_cnt <= '0; ones <= '0;
      end else if (rise_ok) begin
        if (!sdi_q)                          ones <= '0;
        else if (ones != ONES_W'(ONES_MAX))  ones <= ones + 1'b1;
        if (resync) begin
          st <= S_CMD; bit_cnt <= '0;
        end else if (st == S_DATA) begin
          wsh <= {wsh[DATA_W-3:0], sdi_q};
          if (bit_cnt == CNT_W'(DATA_W-1)) begin
            st <= S_CMD; bit_cnt <= '0;
          end else bit_cnt <= bit_cnt + 1'b1;
        end else begin
          cmd_sh <= in_byte[CMD_W-2:0];
          if (bit_cnt == CNT_W'(CMD_W-1)) begin
            bit_cnt <= '0;
            case (kind)
              K_REG:  if (in_byte[6]) begin st <= S_DATA; waddr <= in_byte[5:1]; end
              K_CONV: begin conv_go <= 1'b1; conv_cont <= in_byte[3]; end
              K_CAL:  begin
                cal_go <= 1'b1; cal_sel <= in_byte[4:3];
                cal_gain <= in_byte[1]; cal_offset <= in_byte[0];
              end
              K_PUP:  pwr_up_go <= 1'b1;
              K_PDN:  begin pwr_dn_go <= 1'b1; pwr_dn_mode <= in_byte[4:3]; end
              K_BAD:  cmd_ok <= 1'b0;
              default: ;
            endcase
          end else bit_cnt <= bit_cnt + 1'b1;
        end
      end
    end
  end

  assert_one_strobe_R12: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({conv_go, cal_go, pwr_up_go, pwr_dn_go}));

  assert_strobe_short_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (conv_go | cal_go | pwr_up_go | pwr_dn_go) |=> !(conv_go | cal_go | pwr_up_go | pwr_dn_go));

  assert_strobe_from_edge_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (conv_go | cal_go | pwr_up_go | pwr_dn_go) |-> $past(sclk_rise));

  assert_flag_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !cmd_ok |=> !cmd_ok);

  assert_data_starts_aligned_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_DATA && $past(st) == S_CMD) |-> bit_cnt == '0);
endmodule

// File: tb/cmd_serial_port_bench.sv
module cmd_serial_port_bench;
  localparam int HP = 8;

  logic clk = 1'b0, rst_n = 1'b0, cs_n = 1'b1, sclk = 1'b0, sdi = 1'b0;
  wire  sdo;
  logic cmd_ok, conv_go, conv_cont, cal_go, cal_gain, cal_offset, pwr_up_go, pwr_dn_go;
  logic [1:0] cal_sel, pwr_dn_mode;

  int n_tests = 0, n_fail = 0;
  int c_conv = 0, c_cal = 0, c_pup = 0, c_pdn = 0;
  logic [23:0] model [32];

  always #5 clk = ~clk;

  cmd_serial_port u_cmd_serial_port (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sclk(sclk), .sdi(sdi), .sdo(sdo),
    .cmd_ok(cmd_ok), .conv_go(conv_go), .conv_cont(conv_cont), .cal_go(cal_go),
    .cal_sel(cal_sel), .cal_gain(cal_gain), .cal_offset(cal_offset),
    .pwr_up_go(pwr_up_go), .pwr_dn_go(pwr_dn_go), .pwr_dn_mode(pwr_dn_mode)
  );

  always @(negedge clk) begin
    if (conv_go)   c_conv++;
    if (cal_go)    c_cal++;
    if (pwr_up_go) c_pup++;
    if (pwr_dn_go) c_pdn++;
  end

  function automatic int strobes();
    return c_conv + c_cal + c_pup + c_pdn;
  endfunction

  // 0 nop, 1 register, 2 conv, 3 cal, 4 power-up, 5 power-down, 6 invalid
  function automatic int exp_kind(input logic [7:0] b);
    casez (b)
      8'hFF, 8'hFE:       return 0;
      8'b0??????0:        return 1;
      8'b1110?000:        return 2;
      8'b110??0??:        return 3;
      8'hA0:              return 4;
      8'h80, 8'h88, 8'h90: return 5;
      default:            return 6;
    endcase
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wait_clk(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic do_reset();
    rst_n = 1'b0; cs_n = 1'b1; sclk = 1'b0; sdi = 1'b0;
    wait_clk(4); rst_n = 1'b1; wait_clk(4);
    for (int i = 0; i < 32; i++) model[i] = '0;
  endtask

  task automatic bitx(input logic b, output logic r);
    sdi = b; wait_clk(HP); sclk = 1'b1; r = sdo; wait_clk(HP); sclk = 1'b0;
  endtask

  task automatic xfer(input logic [7:0] tx, output logic [7:0] rx);
    for (int i = 7; i >= 0; i--) bitx(tx[i], rx[i]);
  endtask

  task automatic sel();   wait_clk(HP); cs_n = 1'b0; wait_clk(HP); endtask
  task automatic desel(); wait_clk(HP); cs_n = 1'b1; wait_clk(HP); endtask

  task automatic wr(input logic [4:0] a, input logic [23:0] d);
    logic [7:0] r;
    sel(); xfer({2'b01, a, 1'b0}, r);
    xfer(d[23:16], r); xfer(d[15:8], r); xfer(d[7:0], r);
    desel(); model[a] = d;
  endtask

  task automatic rd(input logic [4:0] a, input int nb, output logic [23:0] got);
    logic [7:0] r;
    got = '0;
    sel(); xfer({2'b00, a, 1'b0}, r);
    for (int i = 0; i < nb; i++) begin xfer(8'hFE, r); got = {got[15:0], r}; end
    desel();
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    n_fail++; n_tests++;
    $display("FAIL watchdog expired");
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    logic [23:0] got, exp;
    logic [7:0]  r;
    logic        rb;
    int          s0;
    void'($urandom(32'd1234));
    do_reset();

    // R1 reset state
    chk(cmd_ok === 1'b1, "R1 cmd_ok", cmd_ok, 1);
    chk(sdo === 1'bz, "R1 sdo hiz", (sdo === 1'bz), 1);
    chk(strobes() == 0, "R1 strobes", strobes(), 0);
    rd(5'd7, 3, got);
    chk(got == 24'h0, "R1 reg zero", got, 0);

    // R2 clocks while deselected: an E0 pattern must not start anything
    s0 = strobes();
    for (int i = 7; i >= 0; i--) bitx(r2_pat(i), rb);
    wait_clk(HP);
    chk(strobes() == s0, "R2 ignored sclk", strobes(), s0);
    chk(sdo === 1'bz, "R2 sdo hiz", (sdo === 1'bz), 1);
    chk(cmd_ok === 1'b1, "R2 flag untouched", cmd_ok, 1);

    // R3 / R4 directed write and full read, then truncated reads
    wr(5'd5, 24'hA5C3F0);
    rd(5'd5, 3, got);
    chk(got == 24'hA5C3F0, "R3 write then read", got, 24'hA5C3F0);
    rd(5'd5, 1, got);
    chk(got == 24'h0000A5, "R4 8-bit read", got, 24'hA5);
    rd(5'd5, 2, got);
    chk(got == 24'h00A5C3, "R4 16-bit read", got, 24'hA5C3);

    // R3 R4 random traffic against model
    for (int it = 0; it < 30; it++) begin
      logic [4:0] a;
      int nb;
      a = 5'($urandom_range(31));
      if ($urandom_range(1) == 1) wr(a, 24'($urandom()));
      else begin
        nb = $urandom_range(3, 1);
        rd(a, nb, got);
        exp = model[a] >> (8 * (3 - nb));
        chk(got == exp, "R4 random read", got, exp);
      end
    end

    // R5 chained read: second byte is a read of another register
    wr(5'd3, 24'h123456); wr(5'd9, 24'hFEDCBA);
    sel(); xfer(8'h06, r);
    xfer(8'hFE, r); chk(r == 8'h12, "R5 first byte", r, 8'h12);
    xfer(8'h12, r); chk(r == 8'h34, "R5 byte during chained cmd", r, 8'h34);
    xfer(8'hFE, r); chk(r == 8'hFE, "R5 chained read msb", r, 8'hFE);
    xfer(8'hFF, r); chk(r == 8'hDC, "R5 chained read mid", r, 8'hDC);
    xfer(8'hFE, r); chk(r == 8'hBA, "R5 chained read lsb", r, 8'hBA);
    desel();

    // R5 + R6 read cut by a start-conversion command
    s0 = c_conv;
    sel(); xfer(8'h06, r);
    xfer(8'hE8, r); chk(r == 8'h12, "R5 byte before cut", r, 8'h12);
    chk(c_conv == s0 + 1 && conv_cont == 1'b1, "R6 continuous start", c_conv - s0, 1);
    xfer(8'hFE, r); chk(r == 8'h00, "R5 read ended", r, 0);
    xfer(8'hE0, r);
    chk(c_conv == s0 + 2 && conv_cont == 1'b0, "R6 single start", conv_cont, 0);
    desel();

    // R7 calibrate fields
    sel(); xfer(8'hD3, r); desel();
    chk(cal_sel == 2'b10 && cal_gain && cal_offset, "R7 cal D3",
        {cal_sel, cal_gain, cal_offset}, 4'b1011);
    sel(); xfer(8'hC8, r); desel();
    chk(cal_sel == 2'b01 && !cal_gain && !cal_offset, "R7 cal C8",
        {cal_sel, cal_gain, cal_offset}, 4'b0100);
    chk(c_cal == 2, "R7 cal count", c_cal, 2);

    // R8 power commands
    sel(); xfer(8'hA0, r); xfer(8'h90, r); desel();
    chk(c_pup == 1, "R8 power-up", c_pup, 1);
    chk(c_pdn == 1 && pwr_dn_mode == 2'b10, "R8 sleep mode", pwr_dn_mode, 2);
    sel(); xfer(8'h80, r); desel();
    chk(c_pdn == 2 && pwr_dn_mode == 2'b00, "R8 soft reset mode", pwr_dn_mode, 0);
    chk(cmd_ok === 1'b1, "R9 flag still ok", cmd_ok, 1);

    // R10 partial byte discarded by CS cycle
    sel(); bitx(1'b1, rb); bitx(1'b0, rb); bitx(1'b1, rb); desel();
    rd(5'd3, 3, got);
    chk(got == 24'h123456, "R10 realign on cs", got, 24'h123456);

    // R11 misaligned by 3 bits, recovered by sync sequence
    sel();
    bitx(1'b1, rb); bitx(1'b1, rb); bitx(1'b1, rb);
    xfer(8'hFF, r); xfer(8'hFF, r); xfer(8'hFF, r); xfer(8'hFE, r);
    xfer(8'h12, r);
    xfer(8'hFE, r); got[23:16] = r;
    xfer(8'hFE, r); got[15:8]  = r;
    xfer(8'hFE, r); got[7:0]   = r;
    desel();
    chk(got == 24'hFEDCBA, "R11 resync read", got, 24'hFEDCBA);
    chk(cmd_ok === 1'b1, "R11 no invalid seen", cmd_ok, 1);

    // R9 invalid command
    s0 = strobes();
    sel(); xfer(8'h98, r); desel();
    chk(cmd_ok === 1'b0, "R9 reserved power mode", cmd_ok, 0);
    chk(strobes() == s0, "R9 no strobe", strobes(), s0);
    sel(); xfer(8'hE0, r); desel();
    chk(cmd_ok === 1'b0, "R9 sticky", cmd_ok, 0);
    do_reset();
    chk(cmd_ok === 1'b1, "R1 flag after reset", cmd_ok, 1);

    // R6 R7 R8 R9 random single command bytes
    for (int it = 0; it < 24; it++) begin
      logic [7:0] b;
      int k;
      b = 8'($urandom());
      if (it < 4) b = {3'b100, 2'b11, 3'b000} ^ 8'(it == 0 ? 0 : it << 5);
      k = exp_kind(b);
      do_reset();
      s0 = strobes();
      sel(); xfer(b, r); desel();
      chk(cmd_ok === (k != 6), "R9 random byte flag", cmd_ok, (k != 6));
      chk(strobes() - s0 == ((k >= 2 && k <= 5) ? 1 : 0), "R12 random byte strobes",
          strobes() - s0, (k >= 2 && k <= 5));
    end

    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  function automatic logic r2_pat(input int i);
    logic [7:0] p = 8'hE0;
    return p[i];
  endfunction
endmodule